// File: doc/BRIEF.md
# Configurable Two-Level Lookup Logic Cell

This block is one logic cell of a programmable-fabric model. Two 4-input lookup tables, F and G, each hold a 16-bit truth table. A third lookup table, H, takes three inputs: the F result, the G result and a dedicated input pin `h1`. Its truth table is 8 bits wide. Because of this cascade, the cell can compute selected functions of up to nine distinct input variables.

Each of the two combinational outputs has its own selection bit. `x` shows either F or H, and `y` shows either G or H. Two storage elements, A and B, sit behind these outputs. Each one takes its data either from its own combinational result or from the direct data input `din`. Each one can be set to run as a rising-edge flip-flop or as a latch that is transparent while the clock is high. Their contents appear on `xq` and `yq`.

A serial shift chain loads the 46 configuration bits, most significant bit first, while `cfg_en` is high. A synchronous active-low reset clears the storage elements and does not change the configuration.

Top module: `lut_cell`

## Requirements
- R1: The F result is bit `f_in` of the 16-bit F table. The G result is bit `g_in` of the 16-bit G table. Table bit i is the result for input value i.
- R2: The H result is bit k of the 8-bit H table, where k = {h1, G result, F result}. Bit 2 of k is `h1` and bit 0 is the F result.
- R3: When the x-select bit is 1, `x` shows H; when it is 0, `x` shows F. When the y-select bit is 1, `y` shows H; when it is 0, `y` shows G.
- R4: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into the chain. After 46 shifts the word is laid out from the first bit sent to the last as follows: F table (bit 15 first), G table (bit 15 first), H table (bit 7 first), x-select, y-select, A-source, B-source, A-latch, B-latch.
- R5: While `cfg_en` is low, the configuration does not change, and a reset leaves it intact.
- R6: While `cfg_en` is high, `x`, `y`, `xq` and `yq` read 0, and both storage elements are cleared.
- R7: A source bit of 1 feeds `din` into that storage element. A source bit of 0 feeds it the combinational result, `x` for A and `y` for B.
- R8: In flip-flop mode (latch bit 0), a storage element captures its data on the rising edge of `clk`. It ignores changes to the data while the clock is high.
- R9: In latch mode (latch bit 1), a storage element follows its data while `clk` is high and holds its value while `clk` is low.
- R10: When `rst_n` is low, both storage elements are cleared. A flip-flop clears at the rising edge, and a latch clears during the clock-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the latch enable when high |
| rst_n | input | 1 | Synchronous active-low reset of the storage elements |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| f_in | input | 4 | F lookup-table inputs |
| g_in | input | 4 | G lookup-table inputs |
| h1 | input | 1 | Free input of the H lookup table |
| din | input | 1 | Direct data input to the storage elements |
| x | output | 1 | Combinational output, F or H |
| y | output | 1 | Combinational output, G or H |
| xq | output | 1 | Storage element A contents |
| yq | output | 1 | Storage element B contents |

## Verification
`x` and `y` are due in the same cycle as the inputs that produce them. `xq` and `yq` are due one rising edge after those inputs, in either storage mode. The driver changes inputs on the falling edge and queues the expected values for all four outputs. The monitor pops each item 3 ns after the following rising edge, inside the high phase, when the combinational and stored results are both valid. A separate check changes `din` in the middle of the high phase and again in the low phase. This makes the latch follow the change in one phase and hold in the other, while the flip-flop does not respond.

// File: rtl/lut_cell_pkg.sv
// Package: shared control-field layout for the logic cell.
// Assumes the control fields occupy the lowest bits of the configuration word.
package lut_cell_pkg;
    // Control bits, first declared field is the most significant bit.
    typedef struct packed {
        logic x_from_h;   // 1: x shows H, 0: x shows F
        logic y_from_h;   // 1: y shows H, 0: y shows G
        logic a_from_din; // 1: element A takes din
        logic b_from_din; // 1: element B takes din
        logic a_latch;    // 1: element A is a latch
        logic b_latch;    // 1: element B is a latch
    } cell_ctrl_t;

    localparam int CTRL_W = $bits(cell_ctrl_t);
    localparam int H_K    = 3;
endpackage

// File: rtl/cfg_chain.sv
// Module: serial configuration shift chain.
// Shifts one bit per rising edge while enabled, MSB first; it holds otherwise.
// Assumes reset does not touch configuration contents.
module cfg_chain #(
    parameter int WIDTH = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] chain_q;

    // Shift the chain left, new bit entering at bit 0.
    always_ff @(posedge clk) begin
        if (shift_en) chain_q <= {chain_q[WIDTH-2:0], ser_in};
    end

    assign word = chain_q;

    // R5: configuration is frozen while the enable is low
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/lut_read.sv
// Module: one lookup table of 2**IN_W entries, read combinationally.
// Assumes table bit i is the output for select value i.
module lut_read #(
    parameter int IN_W = 4
) (
    input  logic [(1<<IN_W)-1:0] table_bits,
    input  logic [IN_W-1:0]      sel,
    output logic                 bit_o
);
    // Index the truth table.
    assign bit_o = table_bits[sel];
endmodule

// File: rtl/store_elem.sv
// Module: storage element with a flip-flop or a latch behaviour chosen at run time.
// The flip-flop captures on the rising clock edge. The latch is transparent while
// clk is high. Reset and clear are synchronous to the clock (the high phase for the latch).
module store_elem (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic latch_mode,
    input  logic d,
    output logic q
);
    logic ff_q;
    logic lat_q;

    // Edge-triggered path.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ff_q <= 1'b0;
        else               ff_q <= d;
    end

    // Level-sensitive path, open while the clock is high.
    always_latch begin
        if (clk) begin
            if (!rst_n || clr) lat_q <= 1'b0;
            else               lat_q <= d;
        end
    end

    // Pick the behaviour selected by configuration.
    assign q = latch_mode ? lat_q : ff_q;

    // R8: in flip-flop mode the output one edge later equals the data captured
    a_r8_ff_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !clr) |=> (latch_mode || q == $past(d)));

    // R10: reset empties the edge-triggered path
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ff_q == 1'b0));
endmodule

// File: rtl/lut_cell.sv
// Module: configurable logic cell with two K-input LUTs cascaded into a
// 3-input LUT, output selection and two mode-selectable storage elements.
// Assumes the configuration is loaded serially before use; outputs read 0 while loading.
module lut_cell #(
    parameter int LUT_K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h1,
    input  logic             din,
    output logic             x,
    output logic             y,
    output logic             xq,
    output logic             yq
);
    import lut_cell_pkg::*;

    localparam int TT_W  = 1 << LUT_K;
    localparam int H_W   = 1 << H_K;
    localparam int CFG_W = 2*TT_W + H_W + CTRL_W;
    localparam int F_LO  = CFG_W - TT_W;
    localparam int G_LO  = F_LO - TT_W;
    localparam int H_LO  = G_LO - H_W;

    logic [CFG_W-1:0] cfg_word;
    cell_ctrl_t       ctrl;
    logic             f_o, g_o, h_o;
    logic             x_raw, y_raw;
    logic [1:0]       comb_raw, from_din, latch_sel, elem_d, elem_q;

    cfg_chain #(.WIDTH(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .ser_in(cfg_din), .word(cfg_word)
    );

    // Split the configuration word into its fields.
    assign ctrl = cell_ctrl_t'(cfg_word[CTRL_W-1:0]);

    lut_read #(.IN_W(LUT_K)) u_f (
        .table_bits(cfg_word[F_LO +: TT_W]), .sel(f_in), .bit_o(f_o)
    );
    lut_read #(.IN_W(LUT_K)) u_g (
        .table_bits(cfg_word[G_LO +: TT_W]), .sel(g_in), .bit_o(g_o)
    );
    lut_read #(.IN_W(H_K)) u_h (
        .table_bits(cfg_word[H_LO +: H_W]), .sel({h1, g_o, f_o}), .bit_o(h_o)
    );

    // Output selection between first-level and cascade results.
    assign x_raw = ctrl.x_from_h ? h_o : f_o;
    assign y_raw = ctrl.y_from_h ? h_o : g_o;

    assign comb_raw  = {y_raw, x_raw};
    assign from_din  = {ctrl.b_from_din, ctrl.a_from_din};
    assign latch_sel = {ctrl.b_latch, ctrl.a_latch};

    // One storage element per output, each with its own source and mode.
    for (genvar i = 0; i < 2; i++) begin : g_store
        assign elem_d[i] = from_din[i] ? din : comb_raw[i];
        store_elem u_se (
            .clk(clk), .rst_n(rst_n), .clr(cfg_en),
            .latch_mode(latch_sel[i]), .d(elem_d[i]), .q(elem_q[i])
        );
    end

    // Gate all outputs while configuration is being shifted.
    assign x  = cfg_en ? 1'b0 : x_raw;
    assign y  = cfg_en ? 1'b0 : y_raw;
    assign xq = cfg_en ? 1'b0 : elem_q[0];
    assign yq = cfg_en ? 1'b0 : elem_q[1];

    // R6: a shift cycle leaves both storage elements empty
    a_r6_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (elem_q == 2'b00));

    // R7: a flip-flop element fed from din holds the previous din
    a_r7_din_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && ctrl.a_from_din && !ctrl.a_latch) |=>
        (cfg_en || !ctrl.a_from_din || ctrl.a_latch || elem_q[0] == $past(din)));
endmodule

// File: tb/lut_cell_tb.sv
module lut_cell_tb;
    localparam int CLK_PERIOD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic h1 = 1'b0, din = 1'b0;
    logic x, y, xq, yq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic ex, ey, exq, eyq;
        string tag;
    } exp_t;
    exp_t sb[$];

    // bench copy of the configuration, set when loading
    logic [15:0] m_f, m_g;
    logic [7:0]  m_h;
    logic m_xh, m_yh, m_ad, m_bd, m_al, m_bl;

    lut_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .f_in(f_in), .g_in(g_in), .h1(h1), .din(din),
        .x(x), .y(y), .xq(xq), .yq(yq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {x,y,xq,yq} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: pop one expected item 3 ns into each high phase.
    always @(posedge clk) begin
        #3;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, {x, y, xq, yq}, {it.ex, it.ey, it.exq, it.eyq});
        end
    end

    // Driver for normal operation: drive at falling edge, queue the expectation.
    task automatic step(logic [3:0] fv, logic [3:0] gv, logic hv, logic dv, logic rst_lo, string tag);
        exp_t it;
        logic fo, go, ho, xo, yo;
        @(negedge clk);
        f_in = fv; g_in = gv; h1 = hv; din = dv; rst_n = !rst_lo;
        fo = m_f[fv];
        go = m_g[gv];
        ho = m_h[{hv, go, fo}];
        xo = m_xh ? ho : fo;
        yo = m_yh ? ho : go;
        it.ex = xo;
        it.ey = yo;
        it.exq = rst_lo ? 1'b0 : (m_ad ? dv : xo);
        it.eyq = rst_lo ? 1'b0 : (m_bd ? dv : yo);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Load a configuration word, MSB first, expecting all-zero outputs (R4, R6).
    task automatic load_cfg(logic [15:0] ft, logic [15:0] gt, logic [7:0] ht,
                            logic xh, logic yh, logic ad, logic bd, logic al, logic bl);
        logic [45:0] w;
        exp_t it;
        w = {ft, gt, ht, xh, yh, ad, bd, al, bl};
        for (int i = 45; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_din = w[i];
            din = 1'b1; f_in = 4'hF; g_in = 4'hF; h1 = 1'b1;
            it.ex = 0; it.ey = 0; it.exq = 0; it.eyq = 0;
            it.tag = "R6 outputs zero while loading";
            sb.push_back(it);
        end
        @(negedge clk);
        cfg_en = 1'b0;
        m_f = ft; m_g = gt; m_h = ht;
        m_xh = xh; m_yh = yh; m_ad = ad; m_bd = bd; m_al = al; m_bl = bl;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R10: reset state of the storage outputs
        repeat (3) @(negedge clk);
        @(posedge clk); #3;
        check("R10 reset state", {1'b0, 1'b0, xq, yq}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // AND4 / OR4 / parity-of-three cascade; x from H, y from G, both from LUTs
        load_cfg(16'h8000, 16'hFFFE, 8'h96, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(4'hF, 4'h0, 1'b0, 1'b0, 1'b0, "R1 R2 R3 R8 AND high");
        step(4'hF, 4'h0, 1'b1, 1'b1, 1'b0, "R2 h1 flips parity");
        step(4'h0, 4'h0, 1'b0, 1'b1, 1'b0, "R1 all zero");
        step(4'h3, 4'h5, 1'b1, 1'b0, 1'b0, "R2 nine inputs mixed");
        step(4'hF, 4'hF, 1'b0, 1'b0, 1'b0, "R7 lut source");
        step(4'h7, 4'h8, 1'b1, 1'b1, 1'b0, "R3 y from G");
        // R10 and R5: reset clears storage, keeps configuration
        step(4'hF, 4'h1, 1'b0, 1'b1, 1'b1, "R10 R5 reset keeps config");
        step(4'hF, 4'h1, 1'b0, 1'b1, 1'b0, "R5 config intact after reset");

        // parity F, NOR G, majority H; x from F, y from H; A latch from din
        load_cfg(16'h6996, 16'h0001, 8'hE8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        step(4'h1, 4'h0, 1'b0, 1'b1, 1'b0, "R1 parity and NOR");
        step(4'h3, 4'h0, 1'b1, 1'b0, 1'b0, "R2 majority");
        step(4'h0, 4'h2, 1'b1, 1'b1, 1'b0, "R7 din source");
        step(4'h7, 4'h0, 1'b0, 1'b0, 1'b0, "R3 x from F");
        step(4'h1, 4'h0, 1'b1, 1'b1, 1'b1, "R10 latch reset");

        // A latch from din, B flip-flop from din
        load_cfg(16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        step(4'h0, 4'h0, 1'b0, 1'b1, 1'b0, "R9 R8 both take din");
        @(posedge clk); #5;
        din = 1'b0;
        #2;
        check("R9 latch follows in high phase / R8 flop holds", {1'b0, 1'b0, xq, yq}, 4'b0001);
        @(negedge clk); #2;
        din = 1'b1;
        #2;
        check("R9 latch holds in low phase", {1'b0, 1'b0, xq, yq}, 4'b0001);
        @(posedge clk); #3;
        check("R8 flop captures at edge", {1'b0, 1'b0, xq, yq}, 4'b0011);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule